// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block owns the command bus of a single-rank, four-bank, 64-bit SDRAM module from reset onward. It first waits out the power-up pause with the clock enable and all byte masks held high, then closes every bank with one precharge-all, runs a fixed number of auto-refresh commands, and writes the mode register with the configured CAS latency, burst type and burst length. When the mode-register settling time has passed it raises `init_done` and stays there.

After initialisation a free-running interval counter marks each refresh slot. Every expired slot adds one to a small saturating count of owed refreshes. While any refresh is owed and the command timing allows one, the block raises `refresh_req` towards the access arbiter and holds it until `refresh_gnt` is seen high, at which point it issues one auto-refresh on the following clock. Every timing given in nanoseconds is turned into whole clock cycles from the `CLK_PS` parameter, always rounding a fraction up and never going below one cycle.

Commands are coded on {cs_n, ras_n, cas_n, we_n}: deselect 1111, NOP 0111, precharge 0010, auto-refresh 0001, mode register set 0000. All outputs are registered.

Top module: `sdram_bringup_seq`

## Requirements
- R1: For ceil(PAUSE_NS/clock period) cycles after reset release the command is deselect (1111), `cke` is high and every `dqm` bit is high; the first non-deselect command appears in exactly that cycle.
- R2: The first command after the pause is precharge (0010) with address bit 10 high and all other address bits and the bank address zero.
- R3: The first auto-refresh (0001) follows the precharge after ceil(T_RP_NS/period) cycles, with NOP (0111) in every cycle between.
- R4: Exactly INIT_REFS auto-refresh commands are issued before `init_done`, each ceil(T_RC_NS/period) cycles after the previous one; no two auto-refresh commands are ever closer than that.
- R5: The mode register set (0000) follows the last initial refresh by ceil(T_RC_NS/period) cycles; its address carries burst length code on A2..A0 (1,2,4,8 -> 0,1,2,3), burst type on A3 (1 = interleave), CAS latency on A6..A4, zeros above; the next cycle is NOP.
- R6: `init_done` rises MRD_CYC cycles after the mode register set, with NOP between, and never falls until reset.
- R7: `refresh_req` first rises ceil(REF_INT_NS/period) cycles after `init_done` rises, then once per such interval, and stays high while `refresh_gnt` is low.
- R8: When `refresh_req` and `refresh_gnt` are both high at a clock edge, auto-refresh appears in the next cycle; `refresh_req` is low in that cycle if no further refresh is owed.
- R9: Owed refreshes accumulate up to MAX_OWED and saturate there; a held grant then drains exactly that many, spaced by the bank cycle time.
- R10: Cycle counts round up: with a 7.5 ns clock the pause is 26667 cycles and the precharge-to-refresh gap is 3 cycles, while a 60 ns bank cycle is exactly 8 cycles.
- R11: While reset is asserted the command is deselect, `cke` is low, `init_done` and `refresh_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_gnt | input | 1 | Arbiter grant for a pending refresh |
| init_done | output | 1 | Initialisation sequence complete |
| refresh_req | output | 1 | A refresh is owed and may be issued |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | DQM_W | Byte masks, held high |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |

## Verification
Each command is registered, so a decision taken at edge n shows on the pins during cycle n; the bench numbers cycles by the edges since reset release and samples at the falling edge, where cycle n's value is stable. A grant driven in cycle c is taken at edge c+1 and its refresh is checked in cycle c+1, and the first request is expected exactly one refresh interval after the cycle `init_done` rose. The expected cycle numbers for two clock periods are worked out from the rounding rule alone, so a count that truncates or is off by one shifts the command by a cycle and misses its table entry.

// File: rtl/sdram_bringup_pkg.sv
`timescale 1ns/1ps
package sdram_bringup_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_MRS   = 4'b0000
  } cmd_t;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE_WAIT,
    ST_INIT_REF,
    ST_MRS_WAIT,
    ST_IDLE,
    ST_REF_WAIT
  } seq_state_t;

  // whole cycles covering a time in ns, fractions rounded up, at least one
  function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
    longint num;
    longint res;
    num = longint'(t_ns) * 1000;
    res = (num + longint'(clk_ps) - 1) / longint'(clk_ps);
    if (res < 1) res = 1;
    return int'(res);
  endfunction

  function automatic logic [2:0] burst_code(input int len);
    case (len)
      1:       return 3'd0;
      2:       return 3'd1;
      4:       return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bringup_wait_timer.sv
`timescale 1ns/1ps
module bringup_wait_timer #(
  parameter int W         = 16,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= W'(RESET_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/bringup_refresh_debt.sv
`timescale 1ns/1ps
module bringup_refresh_debt #(
  parameter int REF_CYC  = 1560,
  parameter int MAX_OWED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic take,
  output logic pending
);
  localparam int IVL_W = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
  localparam int OWE_W = $clog2(MAX_OWED + 1);

  logic [IVL_W-1:0] ivl_q;
  logic [OWE_W-1:0] owed_q;
  logic             tick;

  assign tick = run && (ivl_q == IVL_W'(REF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      owed_q <= '0;
    end else begin
      if (run) ivl_q <= tick ? '0 : ivl_q + 1'b1;
      case ({tick, take})
        2'b10: if (owed_q != OWE_W'(MAX_OWED)) owed_q <= owed_q + 1'b1;
        2'b01: if (owed_q != '0) owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign pending = (owed_q != '0);
endmodule

// File: rtl/sdram_bringup_seq.sv
`timescale 1ns/1ps
module sdram_bringup_seq
  import sdram_bringup_pkg::*;
#(
  parameter int CLK_PS           = 5000,
  parameter int PAUSE_NS         = 200000,
  parameter int T_RP_NS          = 20,
  parameter int T_RC_NS          = 60,
  parameter int REF_INT_NS       = 7800,
  parameter int MRD_CYC          = 2,
  parameter int INIT_REFS        = 8,
  parameter int MAX_OWED         = 4,
  parameter int CAS_LAT          = 3,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int ADDR_W           = 13,
  parameter int BA_W             = 2,
  parameter int DQM_W            = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_gnt,
  output logic              init_done,
  output logic              refresh_req,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PS);
  localparam int RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PS);
  localparam int RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PS);
  localparam int REF_CYC   = ns_to_cyc(REF_INT_NS, CLK_PS);
  localparam int TMR_W     = $clog2(max3(PAUSE_CYC, RC_CYC, max3(RP_CYC, MRD_CYC, 1)) + 1);
  localparam int NREF_W    = $clog2(INIT_REFS + 1);
  localparam int AP_BIT    = 10;
  localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({3'(CAS_LAT), 1'(BURST_INTERLEAVE), burst_code(BURST_LEN)});

  seq_state_t          state_q, state_d;
  cmd_t                cmd_q, cmd_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [NREF_W-1:0]   nref_q, nref_d;
  logic                done_q, done_d;
  logic                cke_q;
  logic                tmr_load, tmr_zero;
  logic [TMR_W-1:0]    tmr_val;
  logic                pending, ready, take;

  bringup_wait_timer #(.W(TMR_W), .RESET_VAL(PAUSE_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  bringup_refresh_debt #(.REF_CYC(REF_CYC), .MAX_OWED(MAX_OWED)) u_debt (
    .clk(clk), .rst_n(rst_n), .run(done_q), .take(take), .pending(pending)
  );

  assign ready       = (state_q == ST_IDLE) || (state_q == ST_REF_WAIT && tmr_zero);
  assign refresh_req = ready && pending;
  assign take        = refresh_req && refresh_gnt;

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    nref_d   = nref_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_PAUSE: begin
        cmd_d = CMD_DESEL;
        if (tmr_zero) begin
          cmd_d    = CMD_PRE;
          addr_d   = PRE_ALL_ADDR;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RP_CYC - 1);
          state_d  = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: if (tmr_zero) begin
        cmd_d    = CMD_REF;
        nref_d   = NREF_W'(1);
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RC_CYC - 1);
        state_d  = ST_INIT_REF;
      end
      ST_INIT_REF: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (nref_q == NREF_W'(INIT_REFS)) begin
          cmd_d   = CMD_MRS;
          addr_d  = MODE_WORD;
          tmr_val = TMR_W'(MRD_CYC - 1);
          state_d = ST_MRS_WAIT;
        end else begin
          cmd_d   = CMD_REF;
          nref_d  = nref_q + 1'b1;
          tmr_val = TMR_W'(RC_CYC - 1);
        end
      end
      ST_MRS_WAIT: if (tmr_zero) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_IDLE, ST_REF_WAIT: begin
        if (take) begin
          cmd_d    = CMD_REF;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RC_CYC - 1);
          state_d  = ST_REF_WAIT;
        end else if (ready) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
      cmd_q   <= CMD_DESEL;
      addr_q  <= '0;
      nref_q  <= '0;
      done_q  <= 1'b0;
      cke_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      nref_q  <= nref_d;
      done_q  <= done_d;
      cke_q   <= 1'b1;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr      = addr_q;
  assign ba        = '0;
  assign cke       = cke_q;
  assign dqm       = {DQM_W{1'b1}};
  assign init_done = done_q;
endmodule

// File: rtl/sdram_bringup_seq_chk.sv
`timescale 1ns/1ps
module sdram_bringup_seq_chk #(
  parameter int RC_CYC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic init_done,
  input logic refresh_req,
  input logic refresh_gnt
);
  localparam int GAP_W = $clog2(RC_CYC + 1);
  logic [3:0]       cmd;
  logic [GAP_W-1:0] since_ref_q;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (!rst_n)                          since_ref_q <= GAP_W'(RC_CYC);
    else if (cmd == 4'b0001)             since_ref_q <= GAP_W'(1);
    else if (since_ref_q < GAP_W'(RC_CYC)) since_ref_q <= since_ref_q + 1'b1;
  end

  assert_cke_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cke);

  assert_ref_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0001) |-> (since_ref_q >= GAP_W'(RC_CYC)));

  assert_mrs_then_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |=> (cmd == 4'b0111));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_gnt) |=> refresh_req);

  assert_req_after_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> init_done);

  assert_grant_issues_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && refresh_gnt) |=> (cmd == 4'b0001));
endmodule

bind sdram_bringup_seq sdram_bringup_seq_chk #(.RC_CYC(RC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .cke(cke), .init_done(init_done), .refresh_req(refresh_req),
  .refresh_gnt(refresh_gnt)
);

// File: tb/sdram_bringup_seq_bench.sv
`timescale 1ns/1ps
module sdram_bringup_seq_bench;
  localparam int WD_CYC = 60000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_gnt = 1'b0;
  always #2.5 clk = ~clk;

  logic m_done, m_req, m_cs, m_ras, m_cas, m_we, m_cke;
  logic [7:0] m_dqm; logic [12:0] m_addr; logic [1:0] m_ba;
  logic a_done, a_req, a_cs, a_ras, a_cas, a_we, a_cke;
  logic [7:0] a_dqm; logic [12:0] a_addr; logic [1:0] a_ba;

  sdram_bringup_seq u_sdram_bringup_seq (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(m_gnt), .init_done(m_done),
    .refresh_req(m_req), .cs_n(m_cs), .ras_n(m_ras), .cas_n(m_cas), .we_n(m_we),
    .cke(m_cke), .dqm(m_dqm), .addr(m_addr), .ba(m_ba));

  sdram_bringup_seq #(.CLK_PS(7500), .CAS_LAT(2), .BURST_LEN(8), .BURST_INTERLEAVE(1))
  u_sdram_bringup_seq_alt (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(1'b0), .init_done(a_done),
    .refresh_req(a_req), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
    .cke(a_cke), .dqm(a_dqm), .addr(a_addr), .ba(a_ba));

  logic [3:0] m_cmd, a_cmd;
  assign m_cmd = {m_cs, m_ras, m_cas, m_we};
  assign a_cmd = {a_cs, a_ras, a_cas, a_we};

  int unsigned cyc = 0;
  int checks = 0, errors = 0;
  int pause_bad = 0, init_refs = 0;
  bit fin = 1'b0;

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // pause window and initial refresh count on the main instance
  always @(negedge clk) if (rst_n) begin
    if (cyc >= 1 && cyc < 40000 && (m_cmd != 4'hF || !m_cke || m_dqm != 8'hFF))
      pause_bad++;
    if (!m_done && m_cmd == 4'h1) init_refs++;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic at_cyc(input int unsigned n);
    while (cyc != n) @(negedge clk);
  endtask

  typedef struct packed {
    logic        alt;
    int unsigned cyc;
    logic [3:0]  cmd;
    logic [12:0] addr;
    logic        done;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 26666, 4'hF, 13'h000, 1'b0, "R10"},
    '{1'b1, 26667, 4'h2, 13'h400, 1'b0, "R10"},
    '{1'b1, 26669, 4'h7, 13'h000, 1'b0, "R10"},
    '{1'b1, 26670, 4'h1, 13'h000, 1'b0, "R10"},
    '{1'b1, 26678, 4'h1, 13'h000, 1'b0, "R10"},
    '{1'b1, 26734, 4'h0, 13'h02B, 1'b0, "R5 "},
    '{1'b1, 26736, 4'h7, 13'h000, 1'b1, "R6 "},
    '{1'b0, 39999, 4'hF, 13'h000, 1'b0, "R1 "},
    '{1'b0, 40000, 4'h2, 13'h400, 1'b0, "R2 "},
    '{1'b0, 40003, 4'h7, 13'h000, 1'b0, "R3 "},
    '{1'b0, 40004, 4'h1, 13'h000, 1'b0, "R3 "},
    '{1'b0, 40015, 4'h7, 13'h000, 1'b0, "R4 "},
    '{1'b0, 40016, 4'h1, 13'h000, 1'b0, "R4 "},
    '{1'b0, 40088, 4'h1, 13'h000, 1'b0, "R4 "},
    '{1'b0, 40099, 4'h7, 13'h000, 1'b0, "R5 "},
    '{1'b0, 40100, 4'h0, 13'h032, 1'b0, "R5 "},
    '{1'b0, 40101, 4'h7, 13'h000, 1'b0, "R6 "},
    '{1'b0, 40102, 4'h7, 13'h000, 1'b1, "R6 "}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(m_cmd == 4'hF, "R11", "cmd in reset", m_cmd, 4'hF);
    chk(m_cke == 1'b0, "R11", "cke in reset", m_cke, 0);
    chk(!m_done && !m_req, "R11", "done/req in reset", {m_done, m_req}, 0);
    chk(m_dqm == 8'hFF, "R1", "dqm in reset", m_dqm, 8'hFF);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      at_cyc(VECS[i].cyc);
      if (VECS[i].alt)
        chk(a_cmd == VECS[i].cmd && a_addr == VECS[i].addr && a_done == VECS[i].done && a_ba == 2'b00,
            $sformatf("%s", VECS[i].tag), "alt cmd/addr/done",
            {a_cmd, a_addr, a_done}, {VECS[i].cmd, VECS[i].addr, VECS[i].done});
      else
        chk(m_cmd == VECS[i].cmd && m_addr == VECS[i].addr && m_done == VECS[i].done && m_ba == 2'b00,
            $sformatf("%s", VECS[i].tag), "main cmd/addr/done",
            {m_cmd, m_addr, m_done}, {VECS[i].cmd, VECS[i].addr, VECS[i].done});
    end

    chk(pause_bad == 0, "R1", "pause cycles not deselect/cke/dqm", pause_bad, 0);
    chk(init_refs == 8, "R4", "initial refresh count", init_refs, 8);

    // R7: first request one interval after init_done
    at_cyc(41661);
    chk(m_req == 1'b0, "R7", "req before interval", m_req, 0);
    at_cyc(41662);
    chk(m_req == 1'b1, "R7", "req at interval", m_req, 1);
    at_cyc(41672);
    chk(m_req == 1'b1 && m_cmd == 4'h7, "R7", "req held, NOP while ungranted", {m_req, m_cmd}, 5'h17);
    m_gnt = 1'b1;
    at_cyc(41673);
    m_gnt = 1'b0;
    chk(m_cmd == 4'h1, "R8", "refresh after grant", m_cmd, 4'h1);
    chk(m_req == 1'b0, "R8", "req drops after grant", m_req, 0);

    // alt instance: 1040-cycle interval, exact division
    // (already past 27776 in time; its request has been held since then)
    chk(a_req == 1'b1, "R7", "alt req held ungranted", a_req, 1);

    // R9: six intervals without grant saturate at four
    at_cyc(51100);
    m_gnt = 1'b1;
    at_cyc(51101);
    chk(m_cmd == 4'h1, "R9", "drain refresh 1", m_cmd, 4'h1);
    at_cyc(51112);
    chk(m_cmd == 4'h7, "R8", "NOP inside bank cycle", m_cmd, 4'h7);
    at_cyc(51113);
    chk(m_cmd == 4'h1, "R9", "drain refresh 2", m_cmd, 4'h1);
    at_cyc(51125);
    chk(m_cmd == 4'h1, "R9", "drain refresh 3", m_cmd, 4'h1);
    at_cyc(51137);
    chk(m_cmd == 4'h1, "R9", "drain refresh 4", m_cmd, 4'h1);
    at_cyc(51149);
    chk(m_cmd == 4'h7 && m_req == 1'b0, "R9", "no fifth refresh", {m_req, m_cmd}, 5'h07);
    m_gnt = 1'b0;
    at_cyc(52581);
    chk(m_req == 1'b0, "R7", "req before next slot", m_req, 0);
    at_cyc(52582);
    chk(m_req == 1'b1 && m_done, "R7", "req at next slot", {m_req, m_done}, 2'b11);

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(WD_CYC * 5.0);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule